// File: doc/BRIEF.md
# Convolution MAC and Accumulate Stage

This block is the arithmetic heart of a streaming convolution engine. On each accepted input beat it multiplies a vector of 36 signed 16-bit feature samples lane by lane with a vector of 36 signed 16-bit kernel weights. It reduces the products in three-input groups, and one final summing stage takes the twelve group sums plus a partial sum. The beat totals are folded into a 40-bit accumulator until the beat flagged as final. The finished sum is then scaled by a programmable arithmetic right shift, rounded half-up and clamped to a signed 16-bit result.

Deep layers are processed as a series of depth slices. The partial sum left by the previous slice arrives on its own valid/ready stream. It is joined with the first beat of each accumulation window, so results build up across iterations. For the first slice a configuration bit makes the stage treat that partial sum as zero and leave its stream untouched. All stages move forward on one shared advance condition, so a stall on the output freezes the whole pipeline.

Two small state machines steer the flow. The window tracker has the states WIN_OPEN and WIN_BODY. It stays in WIN_OPEN after a single-beat window, moves from WIN_OPEN to WIN_BODY on an accepted beat that is not final, and returns from WIN_BODY to WIN_OPEN on an accepted final beat. The accumulator controller mirrors this one stage later with ACC_IDLE and ACC_RUN. In ACC_IDLE an arriving beat starts a fresh sum. In ACC_RUN an arriving beat is added to the running sum. A final beat returns the controller to ACC_IDLE and publishes the result.

Top module: `cmac_stage`

## Requirements
- R1: Lane i of `in_feat` and `in_wgt` occupies bits [16i+15:16i] and is a two's complement signed 16-bit value. The raw beat total is the sum over all 36 lanes of feature times weight.
- R2: Accepted beats are summed into one result until a beat with `in_last`=1 is accepted. Each such window yields exactly one output, in order, and the next beat after a final beat starts a new window.
- R3: When `cfg_first_batch`=0, the first beat of every window is accepted only together with one beat of the partial-sum stream. `in_ready` stays 0 while `psum_valid` is 0 on that beat. The 40-bit signed `psum_data` is added exactly once to that window's total.
- R4: When `cfg_first_batch`=1, the partial-sum input has no effect on any result and `psum_ready` stays 0.
- R5: The total is arithmetically shifted right by `cfg_shift` (0 to 31). For a shift s>0, 2^(s-1) is added before the shift (round half up). A shift of 0 passes the total unchanged. The shift value used is the one present when the result enters the output register.
- R6: The shifted value is clamped to the range -32768 to 32767 before it is driven on `out_data`.
- R7: `sat_seen` rises with the first output that was clamped and stays 1 until reset.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold and `in_ready` is 0.
- R9: With `out_ready` held at 1, the result of a window whose final beat is accepted on clock edge n becomes visible on `out_valid`/`out_data` right after edge n+3.
- R10: After reset `out_valid`=0 and `sat_seen`=0, and any window that was partly received is discarded. The first beat after reset opens a new window.
- R11: Intermediate sums are kept at 40 bits without clamping. A window whose running total far exceeds 16 bits but ends small yields the exact small value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shift | input | 5 | Right-shift amount for output scaling |
| cfg_first_batch | input | 1 | 1: treat the partial sum as zero and leave its stream idle |
| in_valid | input | 1 | Feature/weight beat is valid |
| in_ready | output | 1 | Stage accepts the beat |
| in_last | input | 1 | Beat closes the accumulation window |
| in_feat | input | 576 | 36 packed signed 16-bit feature values |
| in_wgt | input | 576 | 36 packed signed 16-bit weights |
| psum_valid | input | 1 | Partial sum of the previous depth slice is valid |
| psum_ready | output | 1 | Partial sum is consumed this cycle |
| psum_data | input | 40 | Signed partial sum |
| out_valid | output | 1 | Conditioned result is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 16 | Scaled, rounded, saturated result |
| sat_seen | output | 1 | Sticky flag: some result was clamped |

## Verification
The dot product is driven with four input patterns, each of which exposes a different class of fault. Full-range random lanes expose lane-slicing and sign faults in aggregate. Small values in -8..7 keep results unclamped at any shift, so rounding and the partial-sum addition show up exactly. A single active lane pins down its bit position. All-extreme values drive the accumulator to its largest magnitudes. Directed windows then separate the round-half-up rule from truncation at positive and negative ties, show clamping at both rails, and confirm that a large running sum which cancels comes out exact. A random output stall, together with a delayed partial sum, shows whether the join and the global hold lose or duplicate beats.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    // Input-side window tracker
    typedef enum logic {
        WIN_OPEN = 1'b0,
        WIN_BODY = 1'b1
    } win_state_t;

    // Accumulator controller
    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RUN  = 1'b1
    } acc_state_t;

endpackage

// File: rtl/cmac_lanes.sv
module cmac_lanes #(
    parameter int LANES = 36,
    parameter int DW    = 16,
    parameter int ACC_W = 40,
    localparam int PW   = 2 * DW,
    localparam int VW   = LANES * DW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   fire,
    input  logic                   last,
    input  logic [ACC_W-1:0]       psum_sel,
    input  logic [VW-1:0]          feat,
    input  logic [VW-1:0]          wgt,
    output logic                   s1_v,
    output logic                   s1_last,
    output logic [ACC_W-1:0]       s1_psum,
    output logic [LANES*PW-1:0]    prod_flat
);

    // Sideband travelling with the products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_last <= 1'b0;
            s1_psum <= '0;
        end else if (adv) begin
            s1_v    <= fire;
            s1_last <= last;
            s1_psum <= psum_sel;
        end
    end

    // One registered signed multiplier per lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [DW-1:0] fa;
        logic signed [DW-1:0] wb;
        logic signed [PW-1:0] pq;

        assign fa = feat[i*DW +: DW];
        assign wb = wgt[i*DW +: DW];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pq <= '0;
            end else if (adv && fire) begin
                pq <= fa * wb;
            end
        end

        assign prod_flat[i*PW +: PW] = pq;
    end

endmodule

// File: rtl/cmac_tree.sv
module cmac_tree #(
    parameter int LANES = 36,
    parameter int GROUP = 3,
    parameter int DW    = 16,
    parameter int ACC_W = 40,
    localparam int PW   = 2 * DW,
    localparam int NGRP = LANES / GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   s1_v,
    input  logic                   s1_last,
    input  logic [ACC_W-1:0]       s1_psum,
    input  logic [LANES*PW-1:0]    prod_flat,
    output logic                   s2_v,
    output logic                   s2_last,
    output logic [ACC_W-1:0]       s2_sum
);

    logic [ACC_W-1:0] pext [LANES];
    logic [ACC_W-1:0] grp  [NGRP];
    logic [ACC_W-1:0] total;

    // Sign-extend every product to accumulator width
    for (genvar i = 0; i < LANES; i++) begin : g_ext
        assign pext[i] = {{(ACC_W-PW){prod_flat[i*PW+PW-1]}}, prod_flat[i*PW +: PW]};
    end

    // First level: groups of GROUP products
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [ACC_W-1:0] gsum;
        always_comb begin
            gsum = '0;
            for (int k = 0; k < GROUP; k++) begin
                gsum = gsum + pext[g*GROUP + k];
            end
        end
        assign grp[g] = gsum;
    end

    // Final level: NGRP group sums plus the partial sum
    always_comb begin
        total = s1_psum;
        for (int g = 0; g < NGRP; g++) begin
            total = total + grp[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_last <= 1'b0;
            s2_sum  <= '0;
        end else if (adv) begin
            s2_v    <= s1_v;
            s2_last <= s1_last;
            if (s1_v) begin
                s2_sum <= total;
            end
        end
    end

endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
    import cmac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               s2_v,
    input  logic               s2_last,
    input  logic [ACC_W-1:0]   s2_sum,
    output logic               res_v,
    output logic [ACC_W-1:0]   res_sum
);

    acc_state_t       state_q;
    acc_state_t       state_d;
    logic             take;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath select
    always_comb begin
        take    = adv && s2_v;
        state_d = state_q;
        acc_d   = s2_sum;
        unique case (state_q)
            ACC_IDLE: begin
                acc_d = s2_sum;
                if (take && !s2_last) begin
                    state_d = ACC_RUN;
                end
            end
            ACC_RUN: begin
                acc_d = acc_q + s2_sum;
                if (take && s2_last) begin
                    state_d = ACC_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            res_v   <= 1'b0;
            res_sum <= '0;
        end else if (adv) begin
            res_v <= take && s2_last;
            if (take) begin
                acc_q <= acc_d;
                if (s2_last) begin
                    res_sum <= acc_d;
                end
            end
        end
    end

endmodule

// File: rtl/cmac_outcond.sv
module cmac_outcond #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16,
    parameter int SHW   = 5,
    localparam int EW   = ACC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               res_v,
    input  logic [ACC_W-1:0]   res_sum,
    input  logic [SHW-1:0]     shift,
    output logic               out_v,
    output logic [OUT_W-1:0]   out_data,
    output logic               sat_seen
);

    localparam logic signed [EW-1:0] SAT_HI = EW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [EW-1:0] SAT_LO = -SAT_HI - EW'(1);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] half;
    logic signed [EW-1:0] rnd;
    logic signed [EW-1:0] shifted;
    logic [OUT_W-1:0]     clamped;
    logic                 clip;

    always_comb begin
        ext     = {res_sum[ACC_W-1], res_sum};
        half    = (shift == '0) ? '0 : (EW'(1) << (shift - 1'b1));
        rnd     = ext + half;
        shifted = rnd >>> shift;
        clip    = 1'b0;
        if (shifted > SAT_HI) begin
            clamped = SAT_HI[OUT_W-1:0];
            clip    = 1'b1;
        end else if (shifted < SAT_LO) begin
            clamped = SAT_LO[OUT_W-1:0];
            clip    = 1'b1;
        end else begin
            clamped = shifted[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v    <= 1'b0;
            out_data <= '0;
            sat_seen <= 1'b0;
        end else if (adv) begin
            out_v <= res_v;
            if (res_v) begin
                out_data <= clamped;
                if (clip) begin
                    sat_seen <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmac_stage.sv
module cmac_stage
    import cmac_pkg::*;
#(
    parameter int LANES = 36,
    parameter int GROUP = 3,
    parameter int DW    = 16,
    parameter int ACC_W = 40,
    parameter int OUT_W = 16,
    parameter int SHW   = 5,
    localparam int PW   = 2 * DW,
    localparam int VW   = LANES * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHW-1:0]     cfg_shift,
    input  logic               cfg_first_batch,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_last,
    input  logic [VW-1:0]      in_feat,
    input  logic [VW-1:0]      in_wgt,
    input  logic               psum_valid,
    output logic               psum_ready,
    input  logic [ACC_W-1:0]   psum_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic               sat_seen
);

    win_state_t             win_q;
    win_state_t             win_d;
    logic                   adv;
    logic                   need_psum;
    logic                   fire;
    logic [ACC_W-1:0]       psum_sel;

    logic                   s1_v;
    logic                   s1_last;
    logic [ACC_W-1:0]       s1_psum;
    logic [LANES*PW-1:0]    prod_flat;
    logic                   s2_v;
    logic                   s2_last;
    logic [ACC_W-1:0]       s2_sum;
    logic                   res_v;
    logic [ACC_W-1:0]       res_sum;

    // Whole pipeline advances unless the output register is stalled
    assign adv = !out_valid || out_ready;

    // Window tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= WIN_OPEN;
        end else begin
            win_q <= win_d;
        end
    end

    // Window tracker: outputs and next state
    always_comb begin
        need_psum = 1'b0;
        win_d     = win_q;
        unique case (win_q)
            WIN_OPEN: need_psum = !cfg_first_batch;
            WIN_BODY: need_psum = 1'b0;
        endcase
        in_ready   = adv && (!need_psum || psum_valid);
        fire       = in_valid && in_ready;
        psum_ready = fire && need_psum;
        psum_sel   = need_psum ? psum_data : '0;
        if (fire) begin
            win_d = in_last ? WIN_OPEN : WIN_BODY;
        end
    end

    cmac_lanes #(
        .LANES (LANES),
        .DW    (DW),
        .ACC_W (ACC_W)
    ) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .fire      (fire),
        .last      (in_last),
        .psum_sel  (psum_sel),
        .feat      (in_feat),
        .wgt       (in_wgt),
        .s1_v      (s1_v),
        .s1_last   (s1_last),
        .s1_psum   (s1_psum),
        .prod_flat (prod_flat)
    );

    cmac_tree #(
        .LANES (LANES),
        .GROUP (GROUP),
        .DW    (DW),
        .ACC_W (ACC_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .s1_v      (s1_v),
        .s1_last   (s1_last),
        .s1_psum   (s1_psum),
        .prod_flat (prod_flat),
        .s2_v      (s2_v),
        .s2_last   (s2_last),
        .s2_sum    (s2_sum)
    );

    cmac_accum #(
        .ACC_W (ACC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .s2_v    (s2_v),
        .s2_last (s2_last),
        .s2_sum  (s2_sum),
        .res_v   (res_v),
        .res_sum (res_sum)
    );

    cmac_outcond #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .SHW   (SHW)
    ) u_outcond (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .res_v    (res_v),
        .res_sum  (res_sum),
        .shift    (cfg_shift),
        .out_v    (out_valid),
        .out_data (out_data),
        .sat_seen (sat_seen)
    );

endmodule

// File: rtl/cmac_stage_chk.sv
module cmac_stage_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_first_batch,
    input logic             in_valid,
    input logic             in_ready,
    input logic             psum_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             sat_seen
);

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_accept_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_psum_with_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        psum_ready |-> (in_valid && in_ready));

    assert_psum_idle_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_first_batch |-> !psum_ready);

    assert_sticky_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_seen |=> sat_seen);

endmodule

bind cmac_stage cmac_stage_chk #(.OUT_W(OUT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_first_batch (cfg_first_batch),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .psum_ready      (psum_ready),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_data        (out_data),
    .sat_seen        (sat_seen)
);

// File: tb/cmac_stage_bench.sv
module cmac_stage_bench;

    localparam int LANES = 36;
    localparam int DW    = 16;
    localparam int ACC_W = 40;
    localparam int VW    = LANES * DW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       cfg_shift = '0;
    logic             cfg_first_batch = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_last = 1'b0;
    logic [VW-1:0]    in_feat = '0;
    logic [VW-1:0]    in_wgt = '0;
    logic             psum_valid = 1'b0;
    logic             psum_ready;
    logic [ACC_W-1:0] psum_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [15:0]      out_data;
    logic             sat_seen;

    int      checks = 0;
    int      fails = 0;
    longint  expq[$];
    bit      sat_model = 1'b0;
    bit      win_open = 1'b1;
    bit      ready_rand = 1'b0;
    bit      prev_stall = 1'b0;
    logic [15:0] prev_data = '0;
    string   cur_tag = "R1";
    bit      done = 1'b0;

    always #4 clk = ~clk;

    cmac_stage u_cmac_stage (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_shift       (cfg_shift),
        .cfg_first_batch (cfg_first_batch),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_last         (in_last),
        .in_feat         (in_feat),
        .in_wgt          (in_wgt),
        .psum_valid      (psum_valid),
        .psum_ready      (psum_ready),
        .psum_data       (psum_data),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_data        (out_data),
        .sat_seen        (sat_seen)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint dot(input logic [VW-1:0] f, input logic [VW-1:0] w);
        longint s = 0;
        for (int i = 0; i < LANES; i++) begin
            s += longint'($signed(f[i*DW +: DW])) * longint'($signed(w[i*DW +: DW]));
        end
        return s;
    endfunction

    // Requirement model for R5/R6
    function automatic longint cond(input longint v, input int s, output bit clamp);
        longint r = v;
        if (s > 0) r = (v + (64'sd1 <<< (s - 1))) >>> s;
        clamp = 1'b0;
        if (r > 32767) begin r = 32767; clamp = 1'b1; end
        else if (r < -32768) begin r = -32768; clamp = 1'b1; end
        return r;
    endfunction

    task automatic gen(input int pat, output logic [VW-1:0] f, output logic [VW-1:0] w);
        int hot;
        f = '0; w = '0;
        hot = $urandom % LANES;
        for (int i = 0; i < LANES; i++) begin
            case (pat)
                0: begin f[i*DW +: DW] = 16'($urandom); w[i*DW +: DW] = 16'($urandom); end
                1: begin f[i*DW +: DW] = 16'($signed(4'($urandom))); w[i*DW +: DW] = 16'($signed(4'($urandom))); end
                2: if (i == hot) begin f[i*DW +: DW] = 16'($urandom); w[i*DW +: DW] = 16'($urandom); end
                default: begin
                    f[i*DW +: DW] = ($urandom % 2) ? 16'h7FFF : 16'h8000;
                    w[i*DW +: DW] = ($urandom % 2) ? 16'h7FFF : 16'h8000;
                end
            endcase
        end
    endtask

    task automatic send_beat(input logic [VW-1:0] f, input logic [VW-1:0] w,
                             input bit last, input longint pv, input int pdelay);
        int d = pdelay;
        bit need;
        @(negedge clk);
        need = win_open && !cfg_first_batch;
        in_feat = f; in_wgt = w; in_last = last; in_valid = 1'b1;
        psum_data = pv[ACC_W-1:0];
        psum_valid = win_open && (cfg_first_batch || d == 0);
        forever begin
            #2;
            if (cfg_first_batch) chk(psum_ready == 1'b0, "R4 psum_ready", psum_ready, 0);
            if (need && !psum_valid) chk(in_ready == 1'b0, "R3 in_ready without psum", in_ready, 0);
            if (in_ready) break;
            @(negedge clk);
            if (d > 0) d--;
            if (win_open && d == 0) psum_valid = 1'b1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; psum_valid = 1'b0; in_last = 1'b0;
        win_open = last;
    endtask

    task automatic send_window(input int nb, input int pat, input int pdelay);
        logic [VW-1:0] f, w;
        longint pv, tot, r;
        r = {$urandom, $urandom};
        pv = r >>> 27;
        tot = cfg_first_batch ? 0 : pv;
        for (int b = 0; b < nb; b++) begin
            gen(pat, f, w);
            tot += dot(f, w);
            send_beat(f, w, b == nb - 1, pv, (b == 0) ? pdelay : 0);
        end
        expq.push_back(tot);
    endtask

    task automatic send_one(input int lane_f, input int lane_w, input longint pv);
        logic [VW-1:0] f, w;
        f = '0; w = '0;
        f[DW-1:0] = 16'(lane_f); w[DW-1:0] = 16'(lane_w);
        send_beat(f, w, 1'b1, pv, 0);
        expq.push_back((cfg_first_batch ? 0 : pv) + longint'(lane_f) * longint'(lane_w));
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Output side: ready generation and result checking
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_stall = 1'b0;
            out_ready = 1'b1;
        end else begin
            out_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (prev_stall) begin
                chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
                chk(out_data == prev_data, "R8 data held", $signed(out_data), $signed(prev_data));
            end
            if (out_valid && !out_ready) chk(in_ready == 1'b0, "R8 in_ready in stall", in_ready, 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected output", $signed(out_data), 0);
                end else begin
                    bit cl;
                    longint e;
                    e = cond(expq.pop_front(), int'(cfg_shift), cl);
                    chk(longint'($signed(out_data)) == e, cur_tag, $signed(out_data), e);
                    sat_model = sat_model | cl;
                    chk(sat_seen == sat_model, "R7 sat_seen", sat_seen, sat_model);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        chk(sat_seen == 1'b0, "R10 sat_seen after reset", sat_seen, 0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

        // R10: partial window discarded by reset
        begin
            logic [VW-1:0] f, w;
            gen(1, f, w);
            send_beat(f, w, 1'b0, 0, 0);
        end
        @(negedge clk); rst_n = 1'b0;
        expq.delete(); sat_model = 1'b0; win_open = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R10 fresh window";
        send_one(7, 3, 0);
        drain();

        // R1 with the partial-sum stream (R3)
        cfg_first_batch = 1'b0;
        cur_tag = "R3 psum added";
        send_one(-9, 11, 1000);
        send_window(1, 1, 3);
        drain();
        cfg_first_batch = 1'b1;

        // R5 rounding: 5>>1 -> 3, -5>>1 -> -2, 6>>2 -> 2, -6>>2 -> -1
        cur_tag = "R5 round half up";
        cfg_shift = 5'd1;
        send_one(5, 1, 0);
        send_one(-5, 1, 0);
        drain();
        cfg_shift = 5'd2;
        send_one(6, 1, 0);
        send_one(-6, 1, 0);
        drain();
        cfg_shift = 5'd31;
        send_window(2, 3, 0);
        drain();

        // R11: large running sum cancels to 12
        cfg_shift = 5'd0;
        cur_tag = "R11 wide accumulate";
        begin
            logic [VW-1:0] f, w, wn;
            for (int i = 0; i < LANES; i++) begin
                f[i*DW +: DW] = 16'h7FFF; w[i*DW +: DW] = 16'h7FFF; wn[i*DW +: DW] = 16'h8001;
            end
            send_beat(f, w, 1'b0, 0, 0);
            send_beat(f, wn, 1'b0, 0, 0);
            f = '0; w = '0; f[DW-1:0] = 16'd3; w[DW-1:0] = 16'd4;
            send_beat(f, w, 1'b1, 0, 0);
            expq.push_back(12);
        end
        drain();

        // R6/R7: clamp at both rails, flag sticks
        cur_tag = "R6 saturation";
        send_one(200, 100, 0);
        send_one(32767, 32767, 0);
        send_one(-32768, 32767, 0);
        send_one(3, 3, 0);
        drain();
        chk(sat_seen == 1'b1, "R7 sticky after in-range result", sat_seen, 1);

        // R9: fixed latency
        cur_tag = "R9 latency data";
        send_one(2, 2, 0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk); #2;
            chk(out_valid == (k == 4), "R9 latency", out_valid, (k == 4));
        end
        drain();

        // Random groups with output stall and delayed psum
        ready_rand = 1'b1;
        cur_tag = "R1 R2 random windows";
        for (int g = 0; g < 10; g++) begin
            cfg_first_batch = $urandom % 2;
            cfg_shift = 5'($urandom % 32);
            for (int n = 0; n < 6; n++) begin
                send_window(1 + ($urandom % 4), $urandom % 4, $urandom % 3);
            end
            drain();
        end
        ready_rand = 1'b0;
        drain();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule